// File: doc/BRIEF.md
# Digital Line Output Selector with Watchdog Actions

This block drives a bank of bidirectional digital lines. For every line it picks a direction, the source of the value (a static register or the data stream from a timed output engine), and what the line does once a watchdog trip has been seen. On the lowest lines, three auxiliary serial-bus signals can replace the normal data source. Software sets all of this through one narrow write port: a select code, a 32-bit data word and a write strobe.

The watchdog counter lies outside the block. Only its expiry shows up here, as a single-cycle event input. The block latches that event into a sticky trip flag, and a clear strobe removes it. While the flag is set, each line follows its own 2-bit action. It can carry on as normal, hold the value and enable it had in the cycle of the event, release the pin, or drive a bit from a safe-state word. The outputs are a per-line value and a per-line output enable, and a pad ring joins them into tristate buffers.

Top module: `dio_line_mux`

## Requirements
- R1: While reset is asserted, and after it is released, every line has output enable 0 and value 0, and the watchdog trip flag is clear.
- R2: When a line takes no watchdog action, its output enable equals its direction bit (1 = output, 0 = input), and its value is 0 whenever its enable is 0.
- R3: A source-mask bit of 0 sends the static-value bit to the line. A mask bit of 1 sends the matching `timed_data` bit instead.
- R4: Aux-enable bits 0, 1 and 2 make lines 0, 1 and 2 carry `aux_sig[0]`, `aux_sig[1]` and `aux_sig[2]`, whatever the mask and static value say. Output enable still follows direction.
- R5: A write with `cfg_sel` = 0 loads direction, 1 the source mask, 2 the static value, 3 the safe-state word, 4 the aux enables (data bits 2:0), 5 the action word for lines 0–15 and 6 the action word for lines 16–31. The new value acts from the cycle after the write. A write with `cfg_sel` = 7 changes nothing.
- R6: The action of line i sits in bits [2k+1:2k] of its action word, with k = i mod 16. Code 0 means ignore, 1 freeze, 2 tristate and 3 safe value.
- R7: A `wd_event` sets the trip flag, and the line actions apply from the next cycle on. The flag stays set until a `wd_clear` comes in a cycle without `wd_event`, and normal operation returns in the cycle after that clear. An event in the same cycle as a clear wins.
- R8: A freeze-mode line keeps the value and enable it had in the cycle the tripping event arrived, even when data, mask or direction change later.
- R9: A tristate-mode line has enable 0 and value 0 while tripped.
- R10: A safe-mode line has enable equal to its direction bit while tripped, and its value is its safe-state bit when it is an output.
- R11: An ignore-mode line keeps its normal behaviour while tripped.
- R12: A `wd_event` that arrives while the flag is already set does not recapture the frozen values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| timed_data | input | 32 | Per-line data from the timed output engine |
| aux_sig | input | 3 | Auxiliary serial-bus signals for lines 0–2 |
| wd_event | input | 1 | Watchdog expiry event |
| wd_clear | input | 1 | Clears the sticky trip flag |
| line_out | output | 32 | Per-line output value |
| line_oe | output | 32 | Per-line output enable |

## Verification
Some properties are checked on every cycle. The trip flag rises only after an event and falls after a lone clear. Frozen values never move while tripped. Output enables follow direction when not tripped. Tristate lines always release the pin, and safe lines always drive their safe bit. A direction write lands in the following cycle, and a write to the spare code leaves the configuration unchanged.

Other behaviour only shows up in the bench's scenarios. These cover the data-source priority among aux, mask and static, and the field position of each line's action code. They also cover freeze capturing the event-cycle value rather than a later one, a second event not recapturing, and the precedence of event over clear.

// File: rtl/dio_mux_pkg.sv
package dio_mux_pkg;

    // Per-line reaction to a watchdog trip
    typedef enum logic [1:0] {
        WD_IGNORE   = 2'd0,
        WD_FREEZE   = 2'd1,
        WD_TRISTATE = 2'd2,
        WD_SAFE     = 2'd3
    } wd_mode_e;

    // Configuration select codes; action words follow SEL_MODE0 consecutively
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIR    = 3'd0,
        SEL_SRC    = 3'd1,
        SEL_STATIC = 3'd2,
        SEL_SAFE   = 3'd3,
        SEL_AUX    = 3'd4,
        SEL_MODE0  = 3'd5
    } cfg_sel_e;

    localparam logic [SEL_W-1:0] SEL_SPARE = 3'd7;

endpackage

// File: rtl/dio_cfg_regs.sv
module dio_cfg_regs
    import dio_mux_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int AUX_LINES = 3,
    parameter int DATA_W    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [SEL_W-1:0]       sel_i,
    input  logic [DATA_W-1:0]      wdata_i,
    output logic [NUM_LINES-1:0]   dir_o,
    output logic [NUM_LINES-1:0]   src_o,
    output logic [NUM_LINES-1:0]   stat_o,
    output logic [NUM_LINES-1:0]   safe_o,
    output logic [AUX_LINES-1:0]   aux_en_o,
    output logic [2*NUM_LINES-1:0] mode_o
);

    localparam int MODE_BITS  = 2 * NUM_LINES;
    localparam int MODE_WORDS = (MODE_BITS + DATA_W - 1) / DATA_W;
    localparam int MODE_STORE = MODE_WORDS * DATA_W;

    typedef struct packed {
        logic [NUM_LINES-1:0]  dir;
        logic [NUM_LINES-1:0]  src;
        logic [NUM_LINES-1:0]  stat;
        logic [NUM_LINES-1:0]  safe;
        logic [AUX_LINES-1:0]  aux_en;
        logic [MODE_STORE-1:0] mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            case (sel_i)
                SEL_DIR:    cfg_d.dir    = wdata_i[NUM_LINES-1:0];
                SEL_SRC:    cfg_d.src    = wdata_i[NUM_LINES-1:0];
                SEL_STATIC: cfg_d.stat   = wdata_i[NUM_LINES-1:0];
                SEL_SAFE:   cfg_d.safe   = wdata_i[NUM_LINES-1:0];
                SEL_AUX:    cfg_d.aux_en = wdata_i[AUX_LINES-1:0];
                default: begin
                    for (int k = 0; k < MODE_WORDS; k++) begin
                        if (sel_i == SEL_W'(int'(SEL_MODE0) + k)) begin
                            cfg_d.mode[k*DATA_W +: DATA_W] = wdata_i;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign dir_o    = cfg_q.dir;
    assign src_o    = cfg_q.src;
    assign stat_o   = cfg_q.stat;
    assign safe_o   = cfg_q.safe;
    assign aux_en_o = cfg_q.aux_en;
    assign mode_o   = cfg_q.mode[MODE_BITS-1:0];

    // R5: a direction write is visible in the following cycle
    assert_dir_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_DIR) |=> (dir_o == $past(wdata_i[NUM_LINES-1:0])))
        else $error("direction write did not land");

    // R5: the spare select code leaves every register untouched
    assert_spare_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_SPARE) |=> $stable(cfg_q))
        else $error("spare select changed configuration");

endmodule

// File: rtl/dio_wd_latch.sv
module dio_wd_latch #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wd_event_i,
    input  logic                 wd_clear_i,
    input  logic [NUM_LINES-1:0] pre_val_i,
    input  logic [NUM_LINES-1:0] pre_oe_i,
    output logic                 tripped_o,
    output logic [NUM_LINES-1:0] frz_val_o,
    output logic [NUM_LINES-1:0] frz_oe_o
);

    typedef struct packed {
        logic                 tripped;
        logic [NUM_LINES-1:0] frz_val;
        logic [NUM_LINES-1:0] frz_oe;
    } wd_state_t;

    wd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // capture only on the first event of a trip
        if (wd_event_i && !st_q.tripped) begin
            st_d.frz_val = pre_val_i;
            st_d.frz_oe  = pre_oe_i;
        end
        // event takes precedence over a simultaneous clear
        st_d.tripped = wd_event_i | (st_q.tripped & ~wd_clear_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tripped_o = st_q.tripped;
    assign frz_val_o = st_q.frz_val;
    assign frz_oe_o  = st_q.frz_oe;

    assert_event_trips_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_event_i |=> tripped_o)
        else $error("event did not set trip flag");

    assert_no_spurious_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tripped_o && !wd_event_i) |=> !tripped_o)
        else $error("trip flag rose without event");

    assert_clear_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped_o && wd_clear_i && !wd_event_i) |=> !tripped_o)
        else $error("clear did not release trip flag");

    // R8 / R12: frozen snapshot never moves while tripped
    assert_frozen_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tripped_o |=> ($stable(frz_val_o) && $stable(frz_oe_o)))
        else $error("frozen snapshot changed while tripped");

endmodule

// File: rtl/dio_line_cell.sv
module dio_line_cell
    import dio_mux_pkg::*;
(
    input  logic       dir_i,
    input  logic       src_i,
    input  logic       stat_i,
    input  logic       safe_i,
    input  logic [1:0] mode_i,
    input  logic       aux_en_i,
    input  logic       aux_val_i,
    input  logic       timed_i,
    input  logic       tripped_i,
    input  logic       frz_val_i,
    input  logic       frz_oe_i,
    output logic       pre_val_o,
    output logic       pre_oe_o,
    output logic       out_val_o,
    output logic       out_oe_o
);

    logic src_val;

    always_comb begin
        // data source priority: aux override, then timed, then static
        if (aux_en_i) begin
            src_val = aux_val_i;
        end else if (src_i) begin
            src_val = timed_i;
        end else begin
            src_val = stat_i;
        end

        pre_oe_o  = dir_i;
        pre_val_o = dir_i & src_val;

        out_oe_o  = pre_oe_o;
        out_val_o = pre_val_o;
        if (tripped_i) begin
            case (mode_i)
                WD_FREEZE: begin
                    out_oe_o  = frz_oe_i;
                    out_val_o = frz_val_i;
                end
                WD_TRISTATE: begin
                    out_oe_o  = 1'b0;
                    out_val_o = 1'b0;
                end
                WD_SAFE: begin
                    out_oe_o  = dir_i;
                    out_val_o = dir_i & safe_i;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dio_line_mux.sv
module dio_line_mux
    import dio_mux_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int AUX_LINES = 3,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic [NUM_LINES-1:0] timed_data,
    input  logic [AUX_LINES-1:0] aux_sig,
    input  logic                 wd_event,
    input  logic                 wd_clear,
    output logic [NUM_LINES-1:0] line_out,
    output logic [NUM_LINES-1:0] line_oe
);

    logic [NUM_LINES-1:0]   dir_w, src_w, stat_w, safe_w;
    logic [AUX_LINES-1:0]   aux_en_w;
    logic [2*NUM_LINES-1:0] mode_w;
    logic [NUM_LINES-1:0]   pre_val_w, pre_oe_w, frz_val_w, frz_oe_w;
    logic                   tripped_w;

    dio_cfg_regs #(
        .NUM_LINES (NUM_LINES),
        .AUX_LINES (AUX_LINES),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we),
        .sel_i    (cfg_sel),
        .wdata_i  (cfg_wdata),
        .dir_o    (dir_w),
        .src_o    (src_w),
        .stat_o   (stat_w),
        .safe_o   (safe_w),
        .aux_en_o (aux_en_w),
        .mode_o   (mode_w)
    );

    dio_wd_latch #(
        .NUM_LINES (NUM_LINES)
    ) u_wd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wd_event_i (wd_event),
        .wd_clear_i (wd_clear),
        .pre_val_i  (pre_val_w),
        .pre_oe_i   (pre_oe_w),
        .tripped_o  (tripped_w),
        .frz_val_o  (frz_val_w),
        .frz_oe_o   (frz_oe_w)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic aux_en_l, aux_val_l;

        if (i < AUX_LINES) begin : g_aux
            assign aux_en_l  = aux_en_w[i];
            assign aux_val_l = aux_sig[i];
        end else begin : g_plain
            assign aux_en_l  = 1'b0;
            assign aux_val_l = 1'b0;
        end

        dio_line_cell u_cell (
            .dir_i     (dir_w[i]),
            .src_i     (src_w[i]),
            .stat_i    (stat_w[i]),
            .safe_i    (safe_w[i]),
            .mode_i    (mode_w[2*i +: 2]),
            .aux_en_i  (aux_en_l),
            .aux_val_i (aux_val_l),
            .timed_i   (timed_data[i]),
            .tripped_i (tripped_w),
            .frz_val_i (frz_val_w[i]),
            .frz_oe_i  (frz_oe_w[i]),
            .pre_val_o (pre_val_w[i]),
            .pre_oe_o  (pre_oe_w[i]),
            .out_val_o (line_out[i]),
            .out_oe_o  (line_oe[i])
        );

        assert_tristate_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (tripped_w && mode_w[2*i +: 2] == WD_TRISTATE) |-> (!line_oe[i] && !line_out[i]))
            else $error("tristate line still driven");

        assert_safe_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (tripped_w && mode_w[2*i +: 2] == WD_SAFE) |->
                (line_oe[i] == dir_w[i] && (!dir_w[i] || line_out[i] == safe_w[i])))
            else $error("safe line not at safe value");
    end

    assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tripped_w |-> (line_oe == dir_w))
        else $error("enable differs from direction");

    assert_undriven_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_out & ~line_oe) == '0))
        else $error("value set on undriven line");

endmodule

// File: tb/dio_line_mux_test.sv
`timescale 1ns/1ps
module dio_line_mux_test;

    logic        clk;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [31:0] timed_data;
    logic [2:0]  aux_sig;
    logic        wd_event;
    logic        wd_clear;
    logic [31:0] line_out;
    logic [31:0] line_oe;

    int n_vec;
    int n_bad;

    // reference model state
    logic [31:0] m_dir, m_src, m_stat, m_safe, m_fv, m_fo;
    logic [63:0] m_mode;
    logic [2:0]  m_aux;
    logic        m_trip;

    dio_line_mux uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .timed_data (timed_data),
        .aux_sig    (aux_sig),
        .wd_event   (wd_event),
        .wd_clear   (wd_clear),
        .line_out   (line_out),
        .line_oe    (line_oe)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic model_out(input logic [31:0] td, input logic [2:0] ax,
                             output logic [31:0] pv, output logic [31:0] po,
                             output logic [31:0] ov, output logic [31:0] oo);
        for (int i = 0; i < 32; i++) begin
            logic s;
            logic [1:0] md;
            s = (i < 3 && m_aux[i]) ? ax[i] : (m_src[i] ? td[i] : m_stat[i]);
            po[i] = m_dir[i];
            pv[i] = m_dir[i] & s;
            md = m_mode[2*i +: 2];
            if (!m_trip || md == 2'd0) begin
                ov[i] = pv[i]; oo[i] = po[i];
            end else if (md == 2'd1) begin
                ov[i] = m_fv[i]; oo[i] = m_fo[i];
            end else if (md == 2'd2) begin
                ov[i] = 1'b0; oo[i] = 1'b0;
            end else begin
                oo[i] = m_dir[i]; ov[i] = m_dir[i] & m_safe[i];
            end
        end
    endtask

    task automatic check_out(input string tag, input logic [31:0] ev, input logic [31:0] eo);
        n_vec++;
        if (line_out !== ev || line_oe !== eo) begin
            n_bad++;
            $display("FAIL %s: out=%h oe=%h expected out=%h oe=%h", tag, line_out, line_oe, ev, eo);
        end
    endtask

    task automatic step(input logic we, input logic [2:0] sel, input logic [31:0] wd,
                        input logic [31:0] td, input logic [2:0] ax,
                        input logic ev, input logic clr, input string tag);
        logic [31:0] pv, po, ov, oo;
        @(negedge clk);
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        timed_data = td; aux_sig = ax; wd_event = ev; wd_clear = clr;
        #1;
        model_out(td, ax, pv, po, ov, oo);
        check_out(tag, ov, oo);
        if (ev && !m_trip) begin
            m_fv = pv; m_fo = po;
        end
        m_trip = ev | (m_trip & ~clr);
        if (we) begin
            case (sel)
                3'd0: m_dir  = wd;
                3'd1: m_src  = wd;
                3'd2: m_stat = wd;
                3'd3: m_safe = wd;
                3'd4: m_aux  = wd[2:0];
                3'd5: m_mode[31:0]  = wd;
                3'd6: m_mode[63:32] = wd;
                default: ;
            endcase
        end
    endtask

    task automatic idle(input logic [31:0] td, input logic [2:0] ax, input string tag);
        step(1'b0, 3'd0, 32'h0, td, ax, 1'b0, 1'b0, tag);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] wd, input string tag);
        step(1'b1, sel, wd, 32'h0, 3'h0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, out=%h oe=%h expected completion", line_out, line_oe);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        n_vec = 0; n_bad = 0;
        m_dir = '0; m_src = '0; m_stat = '0; m_safe = '0; m_fv = '0; m_fo = '0;
        m_mode = '0; m_aux = '0; m_trip = 1'b0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        timed_data = '0; aux_sig = '0; wd_event = 1'b0; wd_clear = 1'b0;
        void'($urandom(32'h1357_9bdf));

        // R1: reset state, with inputs active
        repeat (3) @(posedge clk);
        @(negedge clk);
        timed_data = 32'hFFFF_FFFF; aux_sig = 3'h7;
        #1;
        check_out("R1 in reset", 32'h0, 32'h0);
        rst_n = 1'b1;
        idle(32'hFFFF_FFFF, 3'h7, "R1 after reset");

        // R2: direction and static value
        wr(3'd2, 32'hA5A5_5A5A, "R5 static write");
        wr(3'd0, 32'hFFFF_0000, "R5 dir write");
        idle(32'h0, 3'h0, "R2 upper outputs");
        wr(3'd0, 32'h0F0F_F0F0, "R2 dir change");
        idle(32'h0, 3'h0, "R2 mixed dir");

        // R3: source mask
        wr(3'd0, 32'hFFFF_FFFF, "R3 all out");
        wr(3'd1, 32'h00FF_00FF, "R3 mask write");
        idle(32'h1234_5678, 3'h0, "R3 timed vs static");
        idle(32'hEDCB_A987, 3'h0, "R3 timed flip");

        // R4: aux override on low lines
        wr(3'd4, 32'hFFFF_FFFD, "R4 aux enable 0,2");
        idle(32'h0000_0000, 3'b101, "R4 aux high");
        idle(32'hFFFF_FFFF, 3'b010, "R4 aux low");
        wr(3'd4, 32'h0, "R4 aux off");
        idle(32'hFFFF_FFFF, 3'b111, "R4 aux disabled");

        // R5: spare select ignored, observed at the ports
        step(1'b1, 3'd7, 32'h0000_0000, 32'h5555_AAAA, 3'h0, 1'b0, 1'b0, "R5 spare write");
        idle(32'h5555_AAAA, 3'h0, "R5 spare no effect");

        // R6: mode packing, line i gets code i mod 4
        wr(3'd5, 32'hE4E4_E4E4, "R6 mode word low");
        wr(3'd6, 32'hE4E4_E4E4, "R6 mode word high");
        wr(3'd3, 32'h3C3C_C3C3, "R10 safe word");
        wr(3'd0, 32'hFFFF_00FF, "R10 dir partial");
        idle(32'h0F0F_0F0F, 3'h0, "R6 modes inert untripped");

        // R7/R8/R9/R10/R11: trip
        step(1'b0, 3'd0, 32'h0, 32'h0F0F_0F0F, 3'h0, 1'b1, 1'b0, "R7 event cycle");
        idle(32'hF0F0_F0F0, 3'h0, "R8 freeze R9 R10 R11 tripped");
        wr(3'd2, 32'h0000_FFFF, "R8 static change tripped");
        wr(3'd0, 32'h0000_FFFF, "R8 dir change tripped");
        idle(32'h3333_CCCC, 3'h0, "R8 hold after changes");
        // R12: second event does not recapture
        step(1'b0, 3'd0, 32'h0, 32'hFFFF_FFFF, 3'h0, 1'b1, 1'b0, "R12 second event");
        idle(32'h0000_0000, 3'h0, "R12 frozen kept");
        // R7: event beats clear
        step(1'b0, 3'd0, 32'h0, 32'h0, 3'h0, 1'b1, 1'b1, "R7 event and clear");
        idle(32'hAAAA_5555, 3'h0, "R7 still tripped");
        step(1'b0, 3'd0, 32'h0, 32'hAAAA_5555, 3'h0, 1'b0, 1'b1, "R7 clear");
        idle(32'hAAAA_5555, 3'h0, "R7 released");
        idle(32'h1111_2222, 3'h0, "R11 normal again");

        // R5 random mix with events and clears
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] & r[1], 3'($urandom_range(0, 7)), $urandom, $urandom, 3'($urandom),
                 (r[7:3] == 5'd0), (r[12:8] < 5'd3), "R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule